// File: doc/BRIEF.md
# Per-Line Retention Refresh Manager

This block keeps a retention budget for every line of a cache built from dynamic cells that lose their charge over time. Each line holds its own measured retention limit, counted in slow time steps, together with an age counter and a lifetime counter. The age and lifetime counters clear when a new block is loaded. Both advance on a shared step strobe that fires once every `TICK_DIV` core cycles. When a line's age comes within one step of its limit, the line is due: it must be refreshed or evicted before its contents decay.

A two-bit policy input chooses what happens to a due line. The first choice is to never refresh, so lines are evicted; dirty lines in a write-back cache are instead refreshed while the write buffer is full. The second choice is to refresh only short-lived lines, until they have lived for a threshold number of steps. The third choice is to always refresh. Refresh grants are one per cycle and go to the lowest due line index. The refreshed line's age clears on the grant. Evictions leave through a held request that carries the line index and a write-back flag, and the request waits for an acknowledge. A line whose limit is programmed to zero is dead and never accepts a block.

Top module: `line_retention_mgr`

## Requirements
- R1: A line whose programmed limit is 0 shows `line_dead_o` high. A load to that line leaves `line_valid_o` low, and the line never produces a refresh or an eviction.
- R2: A load sets the line's `line_valid_o` bit on the next clock edge and clears its age and lifetime counters.
- R3: One step is `TICK_DIV` cycles, and a line is due once its age is at least its limit minus one. With limit L, the first request appears between (L-2)·TICK_DIV+1 and (L-1)·TICK_DIV cycles after the load edge. A refresh names only a valid line.
- R4: With `mode_i` = 2 (full refresh; the value 3 acts the same), every due line is refreshed, and no eviction is ever raised.
- R5: With `mode_i` = 1 (partial refresh), a due line is refreshed only when its limit is below `thresh_i` and its lifetime is below `thresh_i`. Every other due line is evicted.
- R6: With `mode_i` = 0 (no refresh), a due line is evicted. `evict_dirty_o` equals the line's dirty bit when `write_back_i` is 1, and it is 0 when `write_back_i` is 0.
- R7: With `mode_i` = 0, `write_back_i` = 1 and `wbuf_full_i` = 1, a due dirty line is refreshed instead of evicted, while due clean lines are still evicted.
- R8: While `evict_ack_i` is low, a raised eviction keeps its index and flag unchanged. The edge that sees an acknowledge drops the request and clears that line's valid bit, and the next request can appear one cycle later.
- R9: When several lines are waiting for the same resource, the lowest line index is served first.
- R10: A refresh grant clears the line's age counter, so a lone line in full-refresh mode is granted exactly once every (L-1)·TICK_DIV cycles.
- R11: After reset, no line is valid or dead, and neither request output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low reset |
| mode_i | input | 2 | Policy: 0 no refresh, 1 partial, 2 or 3 full |
| write_back_i | input | 1 | 1 when the cache is write-back |
| wbuf_full_i | input | 1 | Write buffer toward the next level is full |
| thresh_i | input | CNT_W | Partial-refresh lifetime threshold, in steps |
| cfg_we_i | input | 1 | Write a line's retention limit |
| cfg_idx_i | input | IDX_W | Line selected for the limit write |
| cfg_limit_i | input | CNT_W | Retention limit in steps (0 marks the line dead) |
| load_i | input | 1 | A new block is placed in a line |
| load_idx_i | input | IDX_W | Line receiving the block |
| load_dirty_i | input | 1 | The loaded block is dirty |
| refresh_vld_o | output | 1 | Refresh granted this cycle |
| refresh_idx_o | output | IDX_W | Line granted the refresh |
| evict_vld_o | output | 1 | Eviction request pending |
| evict_idx_o | output | IDX_W | Line to evict |
| evict_dirty_o | output | 1 | Evicted data must be written back |
| evict_ack_i | input | 1 | Eviction request accepted |
| line_valid_o | output | NUM_LINES | Per-line valid bits |
| line_dead_o | output | NUM_LINES | Per-line dead bits |

## Verification
The assertions assume a well-behaved controller on the inputs. Acknowledges arrive only while an eviction is pending. No block is loaded into a line whose eviction is still waiting. Load and configuration indices stay within the line count, and the threshold stays below the counter's saturation value. The directed tasks follow these rules: they raise the acknowledge only in a cycle where a request is seen and drop it on the following cycle, and they load only lines that are idle. Between scenarios they apply a fresh reset, so no line left in one test can disturb the next.

// File: rtl/lrm_pkg.sv
package lrm_pkg;
   typedef enum logic [1:0] {
      RM_NONE     = 2'd0,
      RM_PARTIAL  = 2'd1,
      RM_FULL     = 2'd2,
      RM_FULL_ALT = 2'd3
   } ret_mode_e;
endpackage

// File: rtl/lrm_tick_gen.sv
module lrm_tick_gen #(
   parameter int DIV = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);
   if (DIV < 1) begin : g_bad_div
      $error("lrm_tick_gen: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick_o = 1'b1;
   end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)             cnt_q <= '0;
         else if (cnt_q == LAST)  cnt_q <= '0;
         else                     cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
         tick_o |=> !tick_o); // R3
   end
endmodule

// File: rtl/lrm_prio_pick.sv
module lrm_prio_pick #(
   parameter int W  = 8,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  req_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o,
   output logic [W-1:0]  gnt_o
);
   always_comb begin
      idx_o = '0;
      gnt_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            idx_o    = IW'(i);
            gnt_o    = '0;
            gnt_o[i] = 1'b1;
         end
      end
   end

   assign any_o = |req_i;
endmodule

// File: rtl/lrm_line.sv
module lrm_line
   import lrm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  ret_mode_e        mode_i,
   input  logic             write_back_i,
   input  logic             wbuf_full_i,
   input  logic [CNT_W-1:0] thresh_i,
   input  logic             cfg_we_i,
   input  logic [CNT_W-1:0] cfg_limit_i,
   input  logic             load_i,
   input  logic             load_dirty_i,
   input  logic             rf_grant_i,
   input  logic             inval_i,
   output logic             valid_o,
   output logic             dead_o,
   output logic             dirty_o,
   output logic             want_rf_o,
   output logic             want_ev_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] limit_q, age_q, life_q;
   logic             valid_q, dirty_q;
   logic [CNT_W:0]   age_next;
   logic             due, keep_alive;

   assign dead_o = (limit_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         limit_q <= CNT_MAX;
         age_q   <= '0;
         life_q  <= '0;
         valid_q <= 1'b0;
         dirty_q <= 1'b0;
      end else begin
         if (cfg_we_i) limit_q <= cfg_limit_i;

         if (cfg_we_i && (cfg_limit_i == '0)) begin
            valid_q <= 1'b0;
         end else if (load_i && !dead_o) begin
            valid_q <= 1'b1;
            dirty_q <= load_dirty_i;
         end else if (inval_i) begin
            valid_q <= 1'b0;
         end

         if (load_i || rf_grant_i)         age_q <= '0;
         else if (tick_i && age_q != CNT_MAX) age_q <= age_q + 1'b1;

         if (load_i)                          life_q <= '0;
         else if (tick_i && life_q != CNT_MAX) life_q <= life_q + 1'b1;
      end
   end

   // one step of margin: due while a full step of charge still remains
   assign age_next = {1'b0, age_q} + 1'b1;
   assign due      = valid_q && (age_next >= {1'b0, limit_q});

   always_comb begin
      unique case (mode_i)
         RM_NONE:    keep_alive = dirty_q && write_back_i && wbuf_full_i;
         RM_PARTIAL: keep_alive = (limit_q < thresh_i) && (life_q < thresh_i);
         default:    keep_alive = 1'b1;
      endcase
   end

   assign want_rf_o = due && keep_alive;
   assign want_ev_o = due && !keep_alive;
   assign valid_o   = valid_q;
   assign dirty_o   = dirty_q;

   AST_DEAD_NOT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dead_o |-> !valid_o); // R1
   AST_GRANT_CLEARS_AGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rf_grant_i |=> (age_q == '0)); // R10
   AST_LOAD_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i && !dead_o && !cfg_we_i |=> valid_o && (life_q == '0)); // R2
endmodule

// File: rtl/line_retention_mgr.sv
module line_retention_mgr
   import lrm_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int CNT_W     = 8,
   parameter int TICK_DIV  = 4,
   localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [1:0]           mode_i,
   input  logic                 write_back_i,
   input  logic                 wbuf_full_i,
   input  logic [CNT_W-1:0]     thresh_i,
   input  logic                 cfg_we_i,
   input  logic [IDX_W-1:0]     cfg_idx_i,
   input  logic [CNT_W-1:0]     cfg_limit_i,
   input  logic                 load_i,
   input  logic [IDX_W-1:0]     load_idx_i,
   input  logic                 load_dirty_i,
   output logic                 refresh_vld_o,
   output logic [IDX_W-1:0]     refresh_idx_o,
   output logic                 evict_vld_o,
   output logic [IDX_W-1:0]     evict_idx_o,
   output logic                 evict_dirty_o,
   input  logic                 evict_ack_i,
   output logic [NUM_LINES-1:0] line_valid_o,
   output logic [NUM_LINES-1:0] line_dead_o
);
   if (NUM_LINES < 2) begin : g_bad_lines
      $error("line_retention_mgr: NUM_LINES must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_width
      $error("line_retention_mgr: CNT_W must be at least 2");
   end

   ret_mode_e              mode_e;
   logic                   tick;
   logic [NUM_LINES-1:0]   want_rf, want_ev, line_dirty, rf_gnt, ev_onehot;
   logic                   rf_any, ev_any;
   logic [IDX_W-1:0]       rf_pick, ev_pick;
   logic                   ev_vld_q, ev_dirty_q;
   logic [IDX_W-1:0]       ev_idx_q;

   assign mode_e = ret_mode_e'(mode_i);

   lrm_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_o(tick)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic hit_cfg, hit_load, hit_inval;
      assign hit_cfg   = cfg_we_i && (cfg_idx_i == IDX_W'(i));
      assign hit_load  = load_i && (load_idx_i == IDX_W'(i));
      assign hit_inval = ev_vld_q && evict_ack_i && (ev_idx_q == IDX_W'(i));

      lrm_line #(.CNT_W(CNT_W)) u_line (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .tick_i      (tick),
         .mode_i      (mode_e),
         .write_back_i(write_back_i),
         .wbuf_full_i (wbuf_full_i),
         .thresh_i    (thresh_i),
         .cfg_we_i    (hit_cfg),
         .cfg_limit_i (cfg_limit_i),
         .load_i      (hit_load),
         .load_dirty_i(load_dirty_i),
         .rf_grant_i  (rf_gnt[i]),
         .inval_i     (hit_inval),
         .valid_o     (line_valid_o[i]),
         .dead_o      (line_dead_o[i]),
         .dirty_o     (line_dirty[i]),
         .want_rf_o   (want_rf[i]),
         .want_ev_o   (want_ev[i])
      );
   end

   lrm_prio_pick #(.W(NUM_LINES), .IW(IDX_W)) u_rf_pick (
      .req_i(want_rf),
      .any_o(rf_any),
      .idx_o(rf_pick),
      .gnt_o(rf_gnt)
   );

   lrm_prio_pick #(.W(NUM_LINES), .IW(IDX_W)) u_ev_pick (
      .req_i(want_ev),
      .any_o(ev_any),
      .idx_o(ev_pick),
      .gnt_o(ev_onehot)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ev_vld_q   <= 1'b0;
         ev_idx_q   <= '0;
         ev_dirty_q <= 1'b0;
      end else if (ev_vld_q) begin
         if (evict_ack_i) ev_vld_q <= 1'b0;
      end else if (ev_any) begin
         ev_vld_q   <= 1'b1;
         ev_idx_q   <= ev_pick;
         ev_dirty_q <= |(ev_onehot & line_dirty) && write_back_i;
      end
   end

   assign refresh_vld_o = rf_any;
   assign refresh_idx_o = rf_pick;
   assign evict_vld_o   = ev_vld_q;
   assign evict_idx_o   = ev_idx_q;
   assign evict_dirty_o = ev_dirty_q;

   AST_EVICT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evict_vld_o && !evict_ack_i |=> evict_vld_o && $stable(evict_idx_o) && $stable(evict_dirty_o)); // R8
   AST_ACK_INVALIDATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evict_vld_o && evict_ack_i && !(load_i && load_idx_i == evict_idx_o)
      |=> !line_valid_o[$past(evict_idx_o)]); // R8
   AST_FULL_NO_EVICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(evict_vld_o) |-> ($past(mode_i) != 2'd2)); // R4
   AST_REFRESH_VALID_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      refresh_vld_o |-> line_valid_o[refresh_idx_o]); // R3
   AST_WT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(evict_vld_o) && !$past(write_back_i) |-> !evict_dirty_o); // R6
endmodule

// File: tb/line_retention_mgr_tb.sv
`timescale 1ns/1ps
module line_retention_mgr_tb;
   localparam int NL = 8;
   localparam int CW = 8;
   localparam int TD = 4;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [1:0]    mode;
   logic          wb, wfull;
   logic [CW-1:0] thresh;
   logic          cfg_we;
   logic [IW-1:0] cfg_idx;
   logic [CW-1:0] cfg_lim;
   logic          ld;
   logic [IW-1:0] ld_idx;
   logic          ld_dirty;
   logic          rf_vld;
   logic [IW-1:0] rf_idx;
   logic          ev_vld;
   logic [IW-1:0] ev_idx;
   logic          ev_dirty;
   logic          ev_ack;
   logic [NL-1:0] vld, dead;

   int n_chk = 0;
   int n_bad = 0;
   int rf_cnt [NL];
   int ev_n;
   int ev_log_idx [16];
   int ev_log_dty [16];

   always #4 clk = ~clk;

   line_retention_mgr #(.NUM_LINES(NL), .CNT_W(CW), .TICK_DIV(TD)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .write_back_i(wb),
      .wbuf_full_i(wfull), .thresh_i(thresh), .cfg_we_i(cfg_we),
      .cfg_idx_i(cfg_idx), .cfg_limit_i(cfg_lim), .load_i(ld),
      .load_idx_i(ld_idx), .load_dirty_i(ld_dirty), .refresh_vld_o(rf_vld),
      .refresh_idx_o(rf_idx), .evict_vld_o(ev_vld), .evict_idx_o(ev_idx),
      .evict_dirty_o(ev_dirty), .evict_ack_i(ev_ack),
      .line_valid_o(vld), .line_dead_o(dead)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; mode = 2'd0; wb = 1'b0; wfull = 1'b0; thresh = '0;
      cfg_we = 1'b0; cfg_idx = '0; cfg_lim = '0; ld = 1'b0; ld_idx = '0;
      ld_dirty = 1'b0; ev_ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic cfg_line(input int idx, input int lim);
      cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_lim = CW'(lim);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load_line(input int idx, input bit dty);
      ld = 1'b1; ld_idx = IW'(idx); ld_dirty = dty;
      @(negedge clk);
      ld = 1'b0;
   endtask

   task automatic clear_log();
      for (int i = 0; i < NL; i++) rf_cnt[i] = 0;
      ev_n = 0;
   endtask

   task automatic run(input int n, input bit ack_on);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         ev_ack = 1'b0;
         if (rf_vld) rf_cnt[rf_idx]++;
         if (ack_on && ev_vld) begin
            if (ev_n < 16) begin
               ev_log_idx[ev_n] = int'(ev_idx);
               ev_log_dty[ev_n] = int'(ev_dirty);
            end
            ev_n++;
            ev_ack = 1'b1;
         end
      end
      if (ev_ack) begin
         @(negedge clk);
         ev_ack = 1'b0;
      end
   endtask

   task automatic t_reset();
      do_reset();
      check(vld == '0, "R11 valid", int'(vld), 0);
      check(dead == '0, "R11 dead", int'(dead), 0);
      check(!rf_vld && !ev_vld, "R11 requests", int'({rf_vld, ev_vld}), 0);
   endtask

   task automatic t_dead();
      do_reset();
      cfg_line(7, 0);
      check(dead[7] == 1'b1, "R1 dead flag", int'(dead[7]), 1);
      load_line(7, 1'b1);
      check(vld[7] == 1'b0, "R1 load ignored", int'(vld[7]), 0);
      clear_log();
      run(40, 1'b1);
      check(rf_cnt[7] == 0 && ev_n == 0, "R1 no requests", rf_cnt[7] + ev_n, 0);
   endtask

   task automatic t_timing_full();
      int c;
      int c2;
      do_reset();
      mode = 2'd2;
      cfg_line(2, 3);
      load_line(2, 1'b0);
      check(vld[2] == 1'b1, "R2 load sets valid", int'(vld[2]), 1);
      c = 0;
      while (!rf_vld && c < 30) begin
         @(negedge clk);
         c++;
      end
      check(c >= (3-2)*TD+1 && c <= (3-1)*TD, "R3 first request window", c, (3-1)*TD);
      check(rf_idx == 3'd2, "R3 refresh index", int'(rf_idx), 2);
      c2 = 0;
      do begin
         @(negedge clk);
         c2++;
      end while (!rf_vld && c2 < 30);
      check(c2 == (3-1)*TD, "R10 refresh period", c2, (3-1)*TD);
      clear_log();
      run(64, 1'b1);
      check(rf_cnt[2] == 8, "R4 refresh count", rf_cnt[2], 8);
      check(ev_n == 0 && vld[2], "R4 no eviction", ev_n, 0);
   endtask

   task automatic t_partial();
      do_reset();
      mode = 2'd1;
      thresh = CW'(6);
      cfg_line(1, 3);
      cfg_line(5, 10);
      load_line(1, 1'b0);
      load_line(5, 1'b0);
      clear_log();
      run(120, 1'b1);
      check(rf_cnt[1] == 2, "R5 short line refreshes", rf_cnt[1], 2);
      check(rf_cnt[5] == 0, "R5 long line never refreshed", rf_cnt[5], 0);
      check(ev_n == 2, "R5 eviction count", ev_n, 2);
      check(ev_log_idx[0] == 1 && ev_log_idx[1] == 5, "R5 eviction order",
            ev_log_idx[0]*10 + ev_log_idx[1], 15);
   endtask

   task automatic t_none();
      do_reset();
      mode = 2'd0;
      wb = 1'b1;
      cfg_line(1, 2);
      cfg_line(4, 2);
      load_line(1, 1'b1);
      load_line(4, 1'b0);
      clear_log();
      run(40, 1'b1);
      check(ev_n == 2, "R6 eviction count", ev_n, 2);
      check(ev_log_idx[0] == 1 && ev_log_dty[0] == 1, "R6 dirty write-back",
            ev_log_idx[0]*10 + ev_log_dty[0], 11);
      check(ev_log_idx[1] == 4 && ev_log_dty[1] == 0, "R6 clean eviction",
            ev_log_idx[1]*10 + ev_log_dty[1], 40);
      check(rf_cnt[1] + rf_cnt[4] == 0, "R6 no refresh", rf_cnt[1] + rf_cnt[4], 0);
      check(vld[1] == 1'b0 && vld[4] == 1'b0, "R8 ack invalidates", int'({vld[4], vld[1]}), 0);
      wb = 1'b0;
      load_line(1, 1'b1);
      clear_log();
      run(40, 1'b1);
      check(ev_n == 1 && ev_log_dty[0] == 0, "R6 write-through flag", ev_log_dty[0], 0);
   endtask

   task automatic t_wbuf();
      do_reset();
      mode = 2'd0;
      wb = 1'b1;
      wfull = 1'b1;
      cfg_line(1, 2);
      cfg_line(4, 2);
      load_line(1, 1'b1);
      load_line(4, 1'b0);
      clear_log();
      run(40, 1'b1);
      check(rf_cnt[1] >= 4, "R7 dirty line refreshed", rf_cnt[1], 4);
      check(ev_n == 1 && ev_log_idx[0] == 4, "R7 clean line evicted", ev_log_idx[0], 4);
      check(vld[1] == 1'b1, "R7 dirty line kept", int'(vld[1]), 1);
      wfull = 1'b0;
      clear_log();
      run(40, 1'b1);
      check(ev_n == 1 && ev_log_idx[0] == 1 && ev_log_dty[0] == 1, "R7 evicted after stall",
            ev_log_idx[0]*10 + ev_log_dty[0], 11);
   endtask

   task automatic t_hold_prio();
      int moved;
      do_reset();
      mode = 2'd0;
      wb = 1'b1;
      cfg_line(0, 2);
      cfg_line(6, 3);
      cfg_line(3, 3);
      load_line(0, 1'b0);
      load_line(6, 1'b1);
      load_line(3, 1'b1);
      moved = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (ev_vld && (ev_idx != 3'd0 || ev_dirty != 1'b0)) moved++;
      end
      check(ev_vld && moved == 0, "R8 request held", moved, 0);
      check(vld[0] == 1'b1, "R8 line valid until ack", int'(vld[0]), 1);
      ev_ack = 1'b1;
      @(negedge clk);
      ev_ack = 1'b0;
      check(vld[0] == 1'b0 && !ev_vld, "R8 ack clears", int'({ev_vld, vld[0]}), 0);
      @(negedge clk);
      check(ev_vld && ev_idx == 3'd3 && ev_dirty, "R9 lowest index first", int'(ev_idx), 3);
      ev_ack = 1'b1;
      @(negedge clk);
      ev_ack = 1'b0;
      @(negedge clk);
      check(ev_vld && ev_idx == 3'd6 && ev_dirty, "R9 next index", int'(ev_idx), 6);
      ev_ack = 1'b1;
      @(negedge clk);
      ev_ack = 1'b0;
   endtask

   initial begin
      #(8ns * 150000);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_dead();
      t_timing_full();
      t_partial();
      t_none();
      t_wbuf();
      t_hold_prio();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule